// File: doc/BRIEF.md
# Capacitive key touch tracker

This block follows one capacitive sense channel. Once per acquisition cycle it receives a signal sample, and from that stream it produces a debounced touch flag. It compares each sample against a reference level that it maintains and lets drift slowly. A touch lowers the signal, so the block measures the distance of the sample below the reference. The block enters or leaves the detect state only after a programmable run of consecutive samples. While the key is in detect, a reduced threshold applies, which gives hysteresis.

The block also guards against a stuck key. If a detection lasts too long, or if the signal jumps too far in the direction away from touch, the block reloads the reference from the live signal and reports the event. A host calibrate request clears the detection at once and reloads the reference on the next sample. Every timer counts samples rather than clock cycles, so all durations scale with the acquisition period. `UNIT_CYCLES` sets how many samples make one time unit; the default of 20 corresponds to the nominal 8 ms cycle.

Top module: `capkey_tracker`

## Requirements
- R1: A sample qualifies as touch when `ref_level - smp_value` is at least `cfg_thresh`. The comparison is unsigned, and a sample above the reference never qualifies.
- R2: Detection starts after N consecutive qualifying samples, where N = `cfg_integ`, except that values 0 and 1 act as 2. `filtering_in` is high while that run is counting, and is never high together with `touch`.
- R3: Detection ends after M consecutive non-qualifying samples. M is the same N as in R2, or exactly 4 when `cfg_fast_out` is 1. A qualifying sample during the exit run keeps the key in detect.
- R4: While `touch` is high, the qualifying threshold is `cfg_thresh - floor(cfg_thresh/8)`. When the key leaves detect, the full threshold applies again.
- R5: Max-on timeout. The sample on which `touch` has already been high for `cfg_maxon*UNIT_CYCLES` samples loads the reference with that sample and clears the detection. `recal_req` is high for the one clock that follows. A `cfg_maxon` of 0 disables the timeout.
- R6: If `smp_value - ref_level` is greater than 4, the reference takes that sample value on the same sample, the detection clears, and `recal_req` pulses for one clock.
- R7: Drift applies only when the key is neither in detect nor filtering in. After 18*`UNIT_CYCLES` consecutive samples below the reference, the reference drops by one. After 6*`UNIT_CYCLES` consecutive samples above it (by 4 or less), the reference rises by one.
- R8: No drift occurs while `drift_hold` or `touch` is high, nor during the 25*`UNIT_CYCLES` samples after both have gone low.
- R9: `cal_req` clears `touch` and `filtering_in` on the next clock. The next valid sample then loads the reference without raising `recal_req`. Reset arms this same load.
- R10: Without a `smp_valid` pulse or a `cal_req`, `touch`, `filtering_in` and `ref_level` hold their values.
- R11: After reset, `touch`, `filtering_in` and `recal_req` are 0 and `ref_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-clock pulse per acquisition cycle |
| smp_value | input | SIG_W | Signal sample |
| cfg_thresh | input | THR_W | Touch threshold in counts (nonzero) |
| cfg_integ | input | DI_W | Consecutive-sample count for entry and exit |
| cfg_fast_out | input | 1 | 1 sets the exit count to 4 |
| cfg_maxon | input | MO_W | Max-on limit in time units, 0 disables |
| drift_hold | input | 1 | Freezes drift (some key in detect) |
| cal_req | input | 1 | Calibrate command pulse |
| touch | output | 1 | Debounced detect flag |
| ref_level | output | SIG_W | Current reference |
| filtering_in | output | 1 | Entry run in progress |
| recal_req | output | 1 | One-clock pulse on internal recalibration |

## Verification
The assertions assume that `cfg_thresh` is never 0 and that the configuration inputs change only between samples. They also assume that `cal_req` never coincides with `smp_valid`, since the request wins and the sample is dropped. The bench respects all three assumptions. It changes settings only while `smp_valid` is low, always programs a threshold of 20, and pulses `cal_req` on a clock that carries no sample. To keep the drift windows short, the bench shrinks the time unit to two samples. Every expected value in the bench is scaled from that unit.

// File: rtl/keyflt_pkg.sv
`timescale 1ns/1ps
package keyflt_pkg;

    localparam int unsigned FAST_OUT_LEN = 4;
    localparam int unsigned MIN_RUN_LEN  = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILT_IN,
        ST_DETECT,
        ST_FILT_OUT
    } key_state_e;

    typedef struct packed {
        logic qual;
        logic jump_away;
        logic below;
        logic above;
    } cmp_flags_t;

    function automatic int unsigned entry_len(input int unsigned di);
        return (di < MIN_RUN_LEN) ? MIN_RUN_LEN : di;
    endfunction

    function automatic int unsigned exit_len(input int unsigned di, input logic fast);
        return fast ? FAST_OUT_LEN : entry_len(di);
    endfunction

    function automatic int unsigned hyst_thr(input int unsigned thr, input logic in_det);
        return in_det ? (thr - (thr >> 3)) : thr;
    endfunction

endpackage

// File: rtl/kf_compare.sv
`timescale 1ns/1ps
module kf_compare
    import keyflt_pkg::*;
#(
    parameter int unsigned SIG_W       = 16,
    parameter int unsigned THR_W       = 8,
    parameter int unsigned POSCAL_STEP = 4
) (
    input  logic [SIG_W-1:0] ref_i,
    input  logic [SIG_W-1:0] sig_i,
    input  logic [THR_W-1:0] thr_i,
    input  logic             det_i,
    output cmp_flags_t       flags_o
);
    logic [THR_W-1:0] eff_thr;
    logic [SIG_W-1:0] gap_down;
    logic [SIG_W-1:0] gap_up;

    assign eff_thr  = THR_W'(hyst_thr(32'(thr_i), det_i));
    assign gap_down = ref_i - sig_i;
    assign gap_up   = sig_i - ref_i;

    assign flags_o.below     = sig_i < ref_i;
    assign flags_o.above     = sig_i > ref_i;
    assign flags_o.qual      = (ref_i >= sig_i) &&
                               (gap_down >= {{(SIG_W-THR_W){1'b0}}, eff_thr});
    assign flags_o.jump_away = (sig_i > ref_i) && (gap_up > SIG_W'(POSCAL_STEP));
endmodule

// File: rtl/kf_integrator.sv
`timescale 1ns/1ps
module kf_integrator
    import keyflt_pkg::*;
#(
    parameter int unsigned DI_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_valid,
    input  logic            cal_req,
    input  logic            clear_now,
    input  logic            qual,
    input  logic [DI_W-1:0] cfg_integ,
    input  logic            cfg_fast_out,
    output logic            det_o,
    output logic            filt_in_o
);
    key_state_e      st;
    logic [DI_W-1:0] cnt;
    logic [31:0]     n_in;
    logic [31:0]     n_out;
    logic [31:0]     cnt_nx;

    assign n_in   = entry_len(32'(cfg_integ));
    assign n_out  = exit_len(32'(cfg_integ), cfg_fast_out);
    assign cnt_nx = 32'(cnt) + 32'd1;

    always_ff @(posedge clk) begin
        if (rst || cal_req) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else if (smp_valid) begin
            if (clear_now) begin
                st  <= ST_IDLE;
                cnt <= '0;
            end else begin
                unique case (st)
                    ST_IDLE: begin
                        if (qual) begin
                            st  <= ST_FILT_IN;
                            cnt <= DI_W'(1);
                        end
                    end
                    ST_FILT_IN: begin
                        if (!qual) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else if (cnt_nx >= n_in) begin
                            st  <= ST_DETECT;
                            cnt <= '0;
                        end else begin
                            cnt <= DI_W'(cnt_nx);
                        end
                    end
                    ST_DETECT: begin
                        if (!qual) begin
                            st  <= ST_FILT_OUT;
                            cnt <= DI_W'(1);
                        end
                    end
                    ST_FILT_OUT: begin
                        if (qual) begin
                            st  <= ST_DETECT;
                            cnt <= '0;
                        end else if (cnt_nx >= n_out) begin
                            st  <= ST_IDLE;
                            cnt <= '0;
                        end else begin
                            cnt <= DI_W'(cnt_nx);
                        end
                    end
                    default: begin
                        st  <= ST_IDLE;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    assign det_o     = (st == ST_DETECT) || (st == ST_FILT_OUT);
    assign filt_in_o = (st == ST_FILT_IN);
endmodule

// File: rtl/kf_maxon.sv
`timescale 1ns/1ps
module kf_maxon #(
    parameter int unsigned MO_W        = 8,
    parameter int unsigned UNIT_CYCLES = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            smp_valid,
    input  logic            cal_req,
    input  logic            clear_now,
    input  logic            det_i,
    input  logic [MO_W-1:0] cfg_maxon,
    output logic            expire_o
);
    localparam int unsigned CW = MO_W + $clog2(UNIT_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [CW:0]   cnt_nx;

    assign limit    = CW'(cfg_maxon) * CW'(UNIT_CYCLES);
    assign cnt_nx   = {1'b0, cnt} + (CW+1)'(1);
    assign expire_o = smp_valid && det_i && (cfg_maxon != '0) && (cnt_nx >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || cal_req) begin
            cnt <= '0;
        end else if (smp_valid) begin
            if (!det_i || clear_now) begin
                cnt <= '0;
            end else if (cnt != '1) begin
                cnt <= cnt_nx[CW-1:0];
            end
        end
    end
endmodule

// File: rtl/kf_reference.sv
`timescale 1ns/1ps
module kf_reference
    import keyflt_pkg::*;
#(
    parameter int unsigned SIG_W           = 16,
    parameter int unsigned UNIT_CYCLES     = 20,
    parameter int unsigned DRIFT_IN_UNITS  = 18,
    parameter int unsigned DRIFT_OUT_UNITS = 6,
    parameter int unsigned HOLD_UNITS      = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic             cal_req,
    input  logic [SIG_W-1:0] sig_i,
    input  logic             load_i,
    input  cmp_flags_t       flags_i,
    input  logic             det_i,
    input  logic             filt_i,
    input  logic             hold_i,
    output logic [SIG_W-1:0] ref_o,
    output logic             cal_pend_o
);
    localparam int unsigned IN_LEN   = DRIFT_IN_UNITS * UNIT_CYCLES;
    localparam int unsigned OUT_LEN  = DRIFT_OUT_UNITS * UNIT_CYCLES;
    localparam int unsigned HOLD_LEN = HOLD_UNITS * UNIT_CYCLES;
    localparam int unsigned IN_W     = $clog2(IN_LEN + 1);
    localparam int unsigned OUT_W    = $clog2(OUT_LEN + 1);
    localparam int unsigned HOLD_W   = $clog2(HOLD_LEN + 1);

    logic [SIG_W-1:0]  ref_q;
    logic              pend_q;
    logic [IN_W-1:0]   dn_cnt;
    logic [OUT_W-1:0]  up_cnt;
    logic [HOLD_W-1:0] hold_cnt;
    logic              drift_ok;

    assign drift_ok = !det_i && !filt_i && !hold_i && (hold_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (det_i || hold_i) begin
            hold_cnt <= HOLD_W'(HOLD_LEN);
        end else if (smp_valid && (hold_cnt != '0)) begin
            hold_cnt <= hold_cnt - HOLD_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cal_req) begin
            pend_q <= 1'b1;
        end else if (smp_valid) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            dn_cnt <= '0;
            up_cnt <= '0;
        end else if (cal_req) begin
            dn_cnt <= '0;
            up_cnt <= '0;
        end else if (smp_valid) begin
            if (load_i) begin
                ref_q  <= sig_i;
                dn_cnt <= '0;
                up_cnt <= '0;
            end else if (drift_ok && flags_i.below) begin
                up_cnt <= '0;
                if (32'(dn_cnt) + 32'd1 >= IN_LEN) begin
                    ref_q  <= ref_q - SIG_W'(1);
                    dn_cnt <= '0;
                end else begin
                    dn_cnt <= dn_cnt + IN_W'(1);
                end
            end else if (drift_ok && flags_i.above) begin
                dn_cnt <= '0;
                if (32'(up_cnt) + 32'd1 >= OUT_LEN) begin
                    ref_q  <= ref_q + SIG_W'(1);
                    up_cnt <= '0;
                end else begin
                    up_cnt <= up_cnt + OUT_W'(1);
                end
            end else begin
                dn_cnt <= '0;
                up_cnt <= '0;
            end
        end
    end

    assign ref_o      = ref_q;
    assign cal_pend_o = pend_q;
endmodule

// File: rtl/capkey_tracker.sv
`timescale 1ns/1ps
module capkey_tracker
    import keyflt_pkg::*;
#(
    parameter int unsigned SIG_W           = 16,
    parameter int unsigned THR_W           = 8,
    parameter int unsigned DI_W            = 8,
    parameter int unsigned MO_W            = 8,
    parameter int unsigned UNIT_CYCLES     = 20,
    parameter int unsigned DRIFT_IN_UNITS  = 18,
    parameter int unsigned DRIFT_OUT_UNITS = 6,
    parameter int unsigned HOLD_UNITS      = 25,
    parameter int unsigned POSCAL_STEP     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_valid,
    input  logic [SIG_W-1:0] smp_value,
    input  logic [THR_W-1:0] cfg_thresh,
    input  logic [DI_W-1:0]  cfg_integ,
    input  logic             cfg_fast_out,
    input  logic [MO_W-1:0]  cfg_maxon,
    input  logic             drift_hold,
    input  logic             cal_req,
    output logic             touch,
    output logic [SIG_W-1:0] ref_level,
    output logic             filtering_in,
    output logic             recal_req
);
    cmp_flags_t flags;
    logic       det;
    logic       filt;
    logic       cal_pend;
    logic       mo_expire;
    logic       recal_now;
    logic       load_now;
    logic       recal_q;

    kf_compare #(
        .SIG_W(SIG_W), .THR_W(THR_W), .POSCAL_STEP(POSCAL_STEP)
    ) u_cmp (
        .ref_i(ref_level), .sig_i(smp_value), .thr_i(cfg_thresh),
        .det_i(det), .flags_o(flags)
    );

    kf_integrator #(.DI_W(DI_W)) u_integ (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .cal_req(cal_req),
        .clear_now(load_now), .qual(flags.qual), .cfg_integ(cfg_integ),
        .cfg_fast_out(cfg_fast_out), .det_o(det), .filt_in_o(filt)
    );

    kf_maxon #(.MO_W(MO_W), .UNIT_CYCLES(UNIT_CYCLES)) u_maxon (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .cal_req(cal_req),
        .clear_now(load_now), .det_i(det), .cfg_maxon(cfg_maxon),
        .expire_o(mo_expire)
    );

    kf_reference #(
        .SIG_W(SIG_W), .UNIT_CYCLES(UNIT_CYCLES), .DRIFT_IN_UNITS(DRIFT_IN_UNITS),
        .DRIFT_OUT_UNITS(DRIFT_OUT_UNITS), .HOLD_UNITS(HOLD_UNITS)
    ) u_ref (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .cal_req(cal_req),
        .sig_i(smp_value), .load_i(load_now), .flags_i(flags), .det_i(det),
        .filt_i(filt), .hold_i(drift_hold), .ref_o(ref_level), .cal_pend_o(cal_pend)
    );

    assign recal_now = smp_valid && !cal_req && !cal_pend && (flags.jump_away || mo_expire);
    assign load_now  = smp_valid && !cal_req && (cal_pend || flags.jump_away || mo_expire);

    always_ff @(posedge clk) begin
        if (rst) begin
            recal_q <= 1'b0;
        end else begin
            recal_q <= recal_now;
        end
    end

    assign touch        = det;
    assign filtering_in = filt;
    assign recal_req    = recal_q;
endmodule

// File: rtl/capkey_tracker_chk.sv
`timescale 1ns/1ps
module capkey_tracker_chk #(
    parameter int unsigned SIG_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic             cal_req,
    input logic             touch,
    input logic             filtering_in,
    input logic [SIG_W-1:0] ref_level,
    input logic             recal_req
);
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !cal_req) |=> ($stable(touch) && $stable(filtering_in) && $stable(ref_level))); // R10

    AST_CAL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        cal_req |=> (!touch && !filtering_in)); // R9

    AST_ENTRY_VIA_FILTER: assert property (@(posedge clk) disable iff (rst)
        $rose(touch) |-> $past(filtering_in)); // R2

    AST_FILTER_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        filtering_in |-> !touch); // R2

    AST_RECAL_DROPS_TOUCH: assert property (@(posedge clk) disable iff (rst)
        recal_req |-> (!touch && !filtering_in)); // R5
endmodule

bind capkey_tracker capkey_tracker_chk #(.SIG_W(SIG_W)) u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .cal_req(cal_req),
    .touch(touch), .filtering_in(filtering_in), .ref_level(ref_level),
    .recal_req(recal_req)
);

// File: tb/capkey_tracker_test.sv
`timescale 1ns/1ps
module capkey_tracker_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid;
    logic [15:0] smp_value;
    logic [7:0]  cfg_thresh;
    logic [7:0]  cfg_integ;
    logic        cfg_fast_out;
    logic [7:0]  cfg_maxon;
    logic        drift_hold;
    logic        cal_req;
    logic        touch;
    logic [15:0] ref_level;
    logic        filtering_in;
    logic        recal_req;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    capkey_tracker #(.UNIT_CYCLES(2)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_value(smp_value),
        .cfg_thresh(cfg_thresh), .cfg_integ(cfg_integ), .cfg_fast_out(cfg_fast_out),
        .cfg_maxon(cfg_maxon), .drift_hold(drift_hold), .cal_req(cal_req),
        .touch(touch), .ref_level(ref_level), .filtering_in(filtering_in),
        .recal_req(recal_req)
    );

    typedef struct packed {
        logic [15:0] sig;
        logic        exp_touch;
        logic        exp_filt;
        logic [15:0] exp_ref;
    } vec_t;

    // threshold 20, integrator 3, no fast-out, no timeout
    localparam vec_t VECS [14] = '{
        '{16'd1000, 1'b0, 1'b0, 16'd1000},  // R9 reset-armed load
        '{16'd985,  1'b0, 1'b0, 16'd1000},  // R1 gap 15 below threshold
        '{16'd980,  1'b0, 1'b1, 16'd1000},  // R1 gap 20 qualifies
        '{16'd979,  1'b0, 1'b1, 16'd1000},  // R2 second of three
        '{16'd978,  1'b1, 1'b0, 16'd1000},  // R2 third -> detect
        '{16'd983,  1'b1, 1'b0, 16'd1000},  // R4 gap 17 < 18, exit run starts
        '{16'd982,  1'b1, 1'b0, 16'd1000},  // R4 gap 18 qualifies in detect
        '{16'd990,  1'b1, 1'b0, 16'd1000},  // R3 exit 1
        '{16'd990,  1'b1, 1'b0, 16'd1000},  // R3 exit 2
        '{16'd990,  1'b0, 1'b0, 16'd1000},  // R3 exit 3 -> release
        '{16'd1000, 1'b0, 1'b0, 16'd1000},
        '{16'd1003, 1'b0, 1'b0, 16'd1000},  // R6 jump of 3 ignored
        '{16'd1005, 1'b0, 1'b0, 16'd1005},  // R6 jump of 5 reloads
        '{16'd1005, 1'b0, 1'b0, 16'd1005}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_value = v;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; smp_valid = 1'b0; smp_value = '0; cfg_thresh = 8'd20;
        cfg_integ = 8'd3; cfg_fast_out = 1'b0; cfg_maxon = 8'd0;
        drift_hold = 1'b0; cal_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 touch", 32'(touch), 0);
        check("R11 filtering_in", 32'(filtering_in), 0);
        check("R11 recal_req", 32'(recal_req), 0);
        check("R11 ref_level", 32'(ref_level), 0);

        for (int i = 0; i < 14; i++) begin
            apply(VECS[i].sig);
            check($sformatf("R1-table[%0d] touch", i), 32'(touch), 32'(VECS[i].exp_touch));
            check($sformatf("R2-table[%0d] filt", i), 32'(filtering_in), 32'(VECS[i].exp_filt));
            check($sformatf("R6-table[%0d] ref", i), 32'(ref_level), 32'(VECS[i].exp_ref));
        end

        // R2: a setting of 0 behaves as 2
        cfg_integ = 8'd0;
        apply(16'd980);
        check("R2 integ0 first", 32'(touch), 0);
        apply(16'd980);
        check("R2 integ0 second", 32'(touch), 1);
        // R3: fast-out gives exit count 4 despite integ 8
        cfg_integ = 8'd8; cfg_fast_out = 1'b1;
        for (int k = 0; k < 3; k++) apply(16'd1005);
        check("R3 fast-out after 3", 32'(touch), 1);
        apply(16'd1005);
        check("R3 fast-out after 4", 32'(touch), 0);

        // R9: calibrate command
        cfg_integ = 8'd2; cfg_fast_out = 1'b0;
        apply(16'd980); apply(16'd980);
        check("R9 pre-cal touch", 32'(touch), 1);
        @(negedge clk); cal_req = 1'b1;
        @(negedge clk); cal_req = 1'b0;
        check("R9 cal clears touch", 32'(touch), 0);
        check("R9 cal clears filt", 32'(filtering_in), 0);
        check("R9 ref held before sample", 32'(ref_level), 1005);
        apply(16'd900);
        check("R9 cal loads ref", 32'(ref_level), 900);
        check("R9 no recal pulse", 32'(recal_req), 0);

        // R5: max-on of 1 unit = 2 samples in detect
        cfg_maxon = 8'd1;
        apply(16'd870); apply(16'd870);
        check("R5 detect", 32'(touch), 1);
        apply(16'd870);
        check("R5 before expiry", 32'(touch), 1);
        apply(16'd870);
        check("R5 expiry clears", 32'(touch), 0);
        check("R5 expiry loads ref", 32'(ref_level), 870);
        check("R5 recal pulse", 32'(recal_req), 1);
        @(negedge clk);
        check("R5 recal one clock", 32'(recal_req), 0);
        // R5: disabled
        cfg_maxon = 8'd0;
        for (int k = 0; k < 12; k++) apply(16'd840);
        check("R5 disabled keeps touch", 32'(touch), 1);
        check("R5 disabled keeps ref", 32'(ref_level), 870);
        apply(16'd870); apply(16'd870);
        check("R3 release integ 2", 32'(touch), 0);

        // R8: hold input freezes drift, then 50-sample window
        drift_hold = 1'b1;
        for (int k = 0; k < 40; k++) apply(16'd865);
        check("R8 hold input", 32'(ref_level), 870);
        drift_hold = 1'b0;
        for (int k = 0; k < 85; k++) apply(16'd865);
        check("R8 window then R7 before step", 32'(ref_level), 870);
        apply(16'd865);
        check("R7 drift toward touch", 32'(ref_level), 869);
        for (int k = 0; k < 11; k++) apply(16'd872);
        check("R7 before upward step", 32'(ref_level), 869);
        apply(16'd872);
        check("R7 drift away from touch", 32'(ref_level), 870);

        // R6: large jump away from touch
        apply(16'd880);
        check("R6 jump reloads", 32'(ref_level), 880);
        check("R6 recal pulse", 32'(recal_req), 1);

        // R10: no sample, no change
        smp_value = 16'd500;
        repeat (6) @(negedge clk);
        check("R10 ref held", 32'(ref_level), 880);
        check("R10 touch held", 32'(touch), 0);
        check("R10 filt held", 32'(filtering_in), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule